// File: doc/BRIEF.md
# Set/Clear Interrupt Flag Controller

This block collects interrupt requests for a contactless reader core. Six one-cycle event pulses come in from neighbouring units: a timer, transmit done, receive done, idle, FIFO high alert and FIFO low alert. Each pulse latches a sticky request flag. A second six-bit register selects which of these flags may reach the interrupt line. Software never writes either register as a plain value. Bit 7 of every write to them picks the operation: set or clear. Each 1 in bits 5..0 then applies that operation to the matching flag, and each 0 leaves its flag alone. This lets software acknowledge one source without a read-modify-write race against new events.

The enabled pending requests are ORed into one pending level. Software can read that level as a status bit. It also drives the interrupt pin, through a small configuration register that selects polarity and selects a push-pull or open-drain output stage. Software reaches the block through an 8-bit register port with a 2-bit address. Writes take effect at the clock edge. Reads are combinational from the addressed register.

Top module: `irqc_top`

## Requirements
- R1: After reset the request and enable registers read 00h, the pin configuration reads 02h, the pending status reads 0, and the pin drives 0 with its output enable at 1.
- R2: A write to the request register (address 1) with bit 7 = 1 sets each flag whose bit in 5..0 is 1 and leaves the rest unchanged. Writing 81h sets only the low-alert flag (bit 0).
- R3: A write to the request register with bit 7 = 0 clears each flag whose bit in 5..0 is 1 and leaves flags at 0-bits unchanged. Writing 3Fh clears all six.
- R4: The enable register (address 0) is written with the same set/clear rule. Its bits map to the same sources as the request register: bit 5 timer, 4 transmit, 3 receive, 2 idle, 1 high alert, 0 low alert.
- R5: An event pulse on `evtPulse[i]` sets request bit i at the next clock edge. The flag then stays set until software clears it.
- R6: When an event and a software clear hit the same flag in the same cycle, the flag ends up set. Other flags cleared by that write end up cleared.
- R7: The pending level is the OR over all sources of (flag AND enable). It reads as bit 0 of address 3, with bits 7..1 of that address reading 0.
- R8: The pin level is the pending level XOR configuration bit 0. With configuration bit 1 = 1 (push-pull), `irqOut` carries the pin level and `irqOe` is 1. With bit 1 = 0 (open-drain), `irqOut` is 0 and `irqOe` is the inverse of the pin level.
- R9: Bits 7 and 6 of the request and enable registers always read 0. A 1 written in bit 6 has no effect.
- R10: The pin configuration (address 2) is written directly from bits 1..0. Bits 7..2 of the write are ignored and read back as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Write strobe for the register port |
| regAddr | input | 2 | Register address: 0 enable, 1 request, 2 pin configuration, 3 status |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Combinational read data for `regAddr` |
| evtPulse | input | 6 | Event pulses from the source units, in request bit order |
| irqOut | output | 1 | Interrupt pin data |
| irqOe | output | 1 | Interrupt pin output enable |

## Verification
Every register update, whether from a write or from an event pulse, lands at the one clock edge that samples the stimulus. The read data, pending status and pin outputs follow that edge combinationally, so each result is due exactly one edge after its stimulus. The bench drives inputs on falling edges, lets exactly one rising edge pass, and samples on the following falling edge, or 1 ns after moving the read address. For the same-cycle race, the event and the clearing write are presented together in one cycle, so both reach the same edge.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int SRC_COUNT = 6;
  localparam int DATA_W    = 8;
  localparam int ADDR_W    = 2;
  localparam int CFG_W     = 2;
  localparam int SET_BIT   = DATA_W - 1;

  localparam logic [ADDR_W-1:0] ADDR_ENABLE  = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_REQUEST = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_PINCFG  = 2'd2;
  localparam logic [ADDR_W-1:0] ADDR_STATUS  = 2'd3;

  // pin configuration: bit0 invert, bit1 push-pull
  localparam logic [CFG_W-1:0] PINCFG_RESET = 2'b10;
  localparam int CFG_INVERT   = 0;
  localparam int CFG_PUSHPULL = 1;

  typedef struct packed {
    logic                 enWr;
    logic                 reqWr;
    logic                 pinWr;
    logic                 setMode;
    logic [SRC_COUNT-1:0] mask;
    logic [CFG_W-1:0]     pinData;
  } strobe_t;
endpackage

// File: rtl/irqc_ctrl.sv
module irqc_ctrl
  import irqc_pkg::*;
(
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output strobe_t           strb
);
  logic unusedGapBits;
  assign unusedGapBits = ^regWrData[SET_BIT-1:SRC_COUNT];

  always_comb begin
    strb         = '0;
    strb.enWr    = regWrEn && (regAddr == ADDR_ENABLE);
    strb.reqWr   = regWrEn && (regAddr == ADDR_REQUEST);
    strb.pinWr   = regWrEn && (regAddr == ADDR_PINCFG);
    strb.setMode = regWrData[SET_BIT];
    strb.mask    = regWrData[SRC_COUNT-1:0];
    strb.pinData = regWrData[CFG_W-1:0];
  end
endmodule

// File: rtl/irqc_flags.sv
module irqc_flags
  import irqc_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              strb,
  input  logic [SRC_COUNT-1:0] evtPulse,
  output logic [SRC_COUNT-1:0] reqFlags,
  output logic [SRC_COUNT-1:0] enFlags,
  output logic [CFG_W-1:0]     pinCfg
);
  for (genvar i = 0; i < SRC_COUNT; i++) begin : g_src
    logic reqSetHit, reqClrHit, enSetHit, enClrHit;
    assign reqSetHit = evtPulse[i] || (strb.reqWr && strb.setMode && strb.mask[i]);
    assign reqClrHit = strb.reqWr && !strb.setMode && strb.mask[i];
    assign enSetHit  = strb.enWr && strb.setMode && strb.mask[i];
    assign enClrHit  = strb.enWr && !strb.setMode && strb.mask[i];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        reqFlags[i] <= 1'b0;
        enFlags[i]  <= 1'b0;
      end else begin
        // set wins over clear, so a hardware event is never lost
        if (reqSetHit)      reqFlags[i] <= 1'b1;
        else if (reqClrHit) reqFlags[i] <= 1'b0;
        if (enSetHit)       enFlags[i]  <= 1'b1;
        else if (enClrHit)  enFlags[i]  <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)           pinCfg <= PINCFG_RESET;
    else if (strb.pinWr) pinCfg <= strb.pinData;
  end
endmodule

// File: rtl/irqc_pin.sv
module irqc_pin
  import irqc_pkg::*;
(
  input  logic [SRC_COUNT-1:0] reqFlags,
  input  logic [SRC_COUNT-1:0] enFlags,
  input  logic [CFG_W-1:0]     pinCfg,
  output logic                 pending,
  output logic                 irqOut,
  output logic                 irqOe
);
  logic pinLevel;
  assign pending  = |(reqFlags & enFlags);
  assign pinLevel = pending ^ pinCfg[CFG_INVERT];

  always_comb begin
    if (pinCfg[CFG_PUSHPULL]) begin
      irqOut = pinLevel;
      irqOe  = 1'b1;
    end else begin
      irqOut = 1'b0;
      irqOe  = !pinLevel;
    end
  end
endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWrEn,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic [DATA_W-1:0]    regWrData,
  output logic [DATA_W-1:0]    regRdData,
  input  logic [SRC_COUNT-1:0] evtPulse,
  output logic                 irqOut,
  output logic                 irqOe
);
  strobe_t              strb;
  logic [SRC_COUNT-1:0] reqFlags;
  logic [SRC_COUNT-1:0] enFlags;
  logic [CFG_W-1:0]     pinCfg;
  logic                 pending;

  irqc_ctrl i_ctrl (
    .regWrEn  (regWrEn),
    .regAddr  (regAddr),
    .regWrData(regWrData),
    .strb     (strb)
  );

  irqc_flags i_flags (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .evtPulse(evtPulse),
    .reqFlags(reqFlags),
    .enFlags (enFlags),
    .pinCfg  (pinCfg)
  );

  irqc_pin i_pin (
    .reqFlags(reqFlags),
    .enFlags (enFlags),
    .pinCfg  (pinCfg),
    .pending (pending),
    .irqOut  (irqOut),
    .irqOe   (irqOe)
  );

  always_comb begin
    regRdData = '0;
    case (regAddr)
      ADDR_ENABLE:  regRdData[SRC_COUNT-1:0] = enFlags;
      ADDR_REQUEST: regRdData[SRC_COUNT-1:0] = reqFlags;
      ADDR_PINCFG:  regRdData[CFG_W-1:0]     = pinCfg;
      default:      regRdData[0]             = pending;
    endcase
  end
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker
  import irqc_pkg::*;
(
  input logic                 clk,
  input logic                 rstN,
  input logic                 regWrEn,
  input logic [ADDR_W-1:0]    regAddr,
  input logic [DATA_W-1:0]    regWrData,
  input logic [SRC_COUNT-1:0] evtPulse,
  input logic [SRC_COUNT-1:0] reqFlags,
  input logic [SRC_COUNT-1:0] enFlags,
  input logic                 irqOut,
  input logic                 irqOe
);
  logic                 reqWr, enWr, setSel;
  logic [SRC_COUNT-1:0] wMask;
  assign reqWr  = regWrEn && (regAddr == ADDR_REQUEST);
  assign enWr   = regWrEn && (regAddr == ADDR_ENABLE);
  assign setSel = regWrData[SET_BIT];
  assign wMask  = regWrData[SRC_COUNT-1:0];

  a_r2_set_write: assert property (@(posedge clk) disable iff (!rstN)
    (reqWr && setSel) |=> ((reqFlags & $past(wMask)) == $past(wMask)));

  a_r3_clear_write: assert property (@(posedge clk) disable iff (!rstN)
    (reqWr && !setSel) |=> ((reqFlags & $past(wMask) & ~$past(evtPulse)) == '0));

  a_r4_enable_hold: assert property (@(posedge clk) disable iff (!rstN)
    !enWr |=> $stable(enFlags));

  a_r4_enable_set: assert property (@(posedge clk) disable iff (!rstN)
    (enWr && setSel) |=> ((enFlags & $past(wMask)) == $past(wMask)));

  a_r5_event_latch: assert property (@(posedge clk) disable iff (!rstN)
    (evtPulse != '0) |=> ((reqFlags & $past(evtPulse)) == $past(evtPulse)));

  a_r5_sticky: assert property (@(posedge clk) disable iff (!rstN)
    !reqWr |=> ((reqFlags & $past(reqFlags)) == $past(reqFlags)));

  a_r8_out_driven: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> irqOe);
endmodule

bind irqc_top irqc_checker i_checker (
  .clk      (clk),
  .rstN     (rstN),
  .regWrEn  (regWrEn),
  .regAddr  (regAddr),
  .regWrData(regWrData),
  .evtPulse (evtPulse),
  .reqFlags (reqFlags),
  .enFlags  (enFlags),
  .irqOut   (irqOut),
  .irqOe    (irqOe)
);

// File: tb/test_irqc_top.sv
`timescale 1ns/1ps
module test_irqc_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWrEn = 1'b0;
  logic [1:0] regAddr = 2'd0;
  logic [7:0] regWrData = 8'h00;
  logic [7:0] regRdData;
  logic [5:0] evtPulse = 6'h00;
  logic       irqOut, irqOe;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  irqc_top i_irqc_top (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .evtPulse(evtPulse),
    .irqOut(irqOut), .irqOe(irqOe)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic readCheck(input string req, input logic [1:0] a, input logic [7:0] exp);
    regAddr = a;
    #1;
    check(req, regRdData, exp);
  endtask

  task automatic pinCheck(input string req, input logic expOut, input logic expOe);
    check(req, {6'b0, irqOut, irqOe}, {6'b0, expOut, expOe});
  endtask

  task automatic t_reset;
    readCheck("R1 request", 2'd1, 8'h00);
    readCheck("R1 enable", 2'd0, 8'h00);
    readCheck("R1 pincfg", 2'd2, 8'h02);
    readCheck("R1 status", 2'd3, 8'h00);
    pinCheck("R1 pin", 1'b0, 1'b1);
  endtask

  task automatic t_set_clear;
    regWrite(2'd1, 8'h81); readCheck("R2 set low alert", 2'd1, 8'h01);
    regWrite(2'd1, 8'hA4); readCheck("R2 set more", 2'd1, 8'h25);
    regWrite(2'd1, 8'h04); readCheck("R3 clear one", 2'd1, 8'h21);
    regWrite(2'd1, 8'h3F); readCheck("R3 clear all", 2'd1, 8'h00);
    regWrite(2'd1, 8'hC0); readCheck("R9 reserved bit", 2'd1, 8'h00);
  endtask

  task automatic t_enable;
    regWrite(2'd0, 8'h9F); readCheck("R4 enable set", 2'd0, 8'h1F);
    regWrite(2'd0, 8'h45); readCheck("R4 enable clear", 2'd0, 8'h1A);
    readCheck("R4 request untouched", 2'd1, 8'h00);
  endtask

  task automatic t_events;
    @(negedge clk); evtPulse = 6'h10;
    @(negedge clk); evtPulse = 6'h00;
    readCheck("R5 event latched", 2'd1, 8'h10);
    repeat (3) @(negedge clk);
    readCheck("R5 sticky", 2'd1, 8'h10);
    readCheck("R7 pending", 2'd3, 8'h01);
    pinCheck("R8 push-pull active", 1'b1, 1'b1);
  endtask

  task automatic t_race;
    @(negedge clk);
    evtPulse = 6'h02; regWrEn = 1'b1; regAddr = 2'd1; regWrData = 8'h12;
    @(negedge clk);
    evtPulse = 6'h00; regWrEn = 1'b0;
    readCheck("R6 event beats clear", 2'd1, 8'h02);
    readCheck("R6 status", 2'd3, 8'h01);
  endtask

  task automatic t_mask;
    regWrite(2'd1, 8'h3F);
    regWrite(2'd1, 8'h81);
    readCheck("R7 masked pending", 2'd3, 8'h00);
    pinCheck("R7 masked pin", 1'b0, 1'b1);
    regWrite(2'd0, 8'h81);
    readCheck("R7 enabled pending", 2'd3, 8'h01);
  endtask

  task automatic t_pin;
    regWrite(2'd2, 8'h03); pinCheck("R8 inverted push-pull", 1'b0, 1'b1);
    regWrite(2'd2, 8'h00); pinCheck("R8 open-drain released", 1'b0, 1'b0);
    regWrite(2'd2, 8'h01); pinCheck("R8 open-drain driven", 1'b0, 1'b1);
    regWrite(2'd2, 8'hFE); readCheck("R10 upper ignored", 2'd2, 8'h02);
    pinCheck("R10 push-pull back", 1'b1, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_set_clear();
    t_enable();
    t_events();
    t_race();
    t_mask();
    t_pin();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end
endmodule